// File: doc/BRIEF.md
# Next-PC Sequencer with Architectural Delay Slot

This block decides which address the front end of a 32-bit register-compare RISC core fetches next. Each accepted step carries the decoded control-flow class of the instruction at the current fetch address. It also carries two register operands, a 16-bit branch offset, a 26-bit jump index and the link and likely qualifiers. There are no condition flags. Conditional branches compare register values directly, either against each other or against zero.

Every taken jump or branch leaves one delay slot. The instruction at the next sequential address is always issued before the redirect takes effect. A likely branch that falls through cancels that slot: the block raises `annul` while the slot instruction is accepted. Link forms report the return address and a write enable for register 31. A step is accepted only when `in_valid` and `in_ready` are both high.

The controller has three named states. RUN is normal sequential issue. SLOT means a redirect is pending and the current instruction is its delay slot. SQUASH means the current instruction is the delay slot of a likely branch that was not taken. The transitions, each taken on an accepted step, are:
- RUN→SLOT on a taken transfer.
- RUN→SQUASH on a likely branch that falls through.
- RUN→RUN for any other instruction.
- SLOT→RUN, which loads the pending target.
- SQUASH→RUN, which advances by 4.

Top module: `npc_sequencer`

## Requirements
- R1: After reset, `fetch_pc` is 0xBFC00000, the state is RUN, and `link_we` and `annul` are low.
- R2: While no step is accepted (`in_valid` or `in_ready` low), `fetch_pc` and any pending target hold, and `link_we` and `annul` stay low.
- R3: The `cf_kind` codes are: 0 none, 1 direct jump, 2 register jump, 3 equal, 4 not equal, 5 ≥0, 6 >0, 7 ≤0, 8 <0. Codes 9 to 15 act as none. An accepted non-transfer in RUN advances `fetch_pc` by 4.
- R4: After a taken transfer at address P, the next fetch is P+4, which is the delay slot. Once the slot is accepted, the next fetch is the target.
- R5: A direct jump at P targets {P[31:28], `jmp_idx`, 2'b00}.
- R6: A register jump targets the full value of `op_a`.
- R7: A branch at P targets P+4 plus the sign-extended `br_off` shifted left by two. Code 3 is taken when `op_a` equals `op_b`, and code 4 when they differ.
- R8: Codes 5 to 8 compare `op_a` with zero as a two's complement value whose sign is bit 31.
- R9: A transfer with `cf_link` high raises `link_we` in its accepted cycle, with `link_data` equal to P+8. For branches this holds whether or not the branch is taken.
- R10: A likely branch (`cf_likely` high) that is not taken raises `annul` while its slot instruction is accepted. Fetch then continues at P+8.
- R11: A likely branch that is taken, and an ordinary branch that is not taken, never raise `annul`.
- R12: A transfer presented as a delay-slot instruction is treated as a non-transfer: no link write and no change to the pending redirect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Decoded fields are present |
| in_ready | input | 1 | Consumer can take the step |
| cf_kind | input | 4 | Control-flow class code (see R3) |
| cf_link | input | 1 | Link form: write return address to r31 |
| cf_likely | input | 1 | Likely form: cancel slot when not taken |
| op_a | input | 32 | First register operand / jump register |
| op_b | input | 32 | Second register operand |
| br_off | input | 16 | Branch word offset |
| jmp_idx | input | 26 | Direct jump word index |
| fetch_pc | output | 32 | Address of the instruction now presented |
| link_we | output | 1 | Write enable for register 31 |
| link_data | output | 32 | Return address |
| annul | output | 1 | Accepted instruction must not commit |

## Verification
The hardest situations to reach from the ports are a stall while a redirect is pending and a transfer sitting in a delay slot. Both require the controller to be in SLOT when the stimulus arrives. The bench gets there by issuing a taken jump and then holding `in_ready` low for several cycles before presenting the slot. In the same way it presents a linked jump as the slot instruction. In both cases the fetch sequence must still land on the first target, and in the second no link write may appear.

// File: rtl/npc_pkg.sv
package npc_pkg;
    typedef enum logic [3:0] {
        CF_NONE = 4'd0,
        CF_JUMP = 4'd1,
        CF_JREG = 4'd2,
        CF_BEQ  = 4'd3,
        CF_BNE  = 4'd4,
        CF_BGEZ = 4'd5,
        CF_BGTZ = 4'd6,
        CF_BLEZ = 4'd7,
        CF_BLTZ = 4'd8
    } cf_kind_e;

    typedef enum logic [1:0] {
        SQ_RUN    = 2'd0,
        SQ_SLOT   = 2'd1,
        SQ_SQUASH = 2'd2
    } seq_state_e;
endpackage

// File: rtl/npc_branch_cmp.sv
module npc_branch_cmp
    import npc_pkg::*;
#(
    parameter int XLEN = 32
) (
    input  logic [3:0]      kind,
    input  logic [XLEN-1:0] a,
    input  logic [XLEN-1:0] b,
    output logic            is_branch,
    output logic            cond_true
);
    logic neg;
    logic zero;
    logic same;

    assign neg  = a[XLEN-1];
    assign zero = (a == '0);
    assign same = (a == b);

    always_comb begin
        is_branch = 1'b1;
        cond_true = 1'b0;
        unique case (kind)
            CF_BEQ:  cond_true = same;
            CF_BNE:  cond_true = !same;
            CF_BGEZ: cond_true = !neg;
            CF_BGTZ: cond_true = !neg && !zero;
            CF_BLEZ: cond_true = neg || zero;
            CF_BLTZ: cond_true = neg;
            default: is_branch = 1'b0;
        endcase
    end
endmodule

// File: rtl/npc_target_gen.sv
module npc_target_gen
    import npc_pkg::*;
#(
    parameter int XLEN   = 32,
    parameter int OFF_W  = 16,
    parameter int JIDX_W = 26
) (
    input  logic [XLEN-1:0]   pc,
    input  logic [3:0]        kind,
    input  logic [XLEN-1:0]   a,
    input  logic [OFF_W-1:0]  off,
    input  logic [JIDX_W-1:0] jidx,
    output logic [XLEN-1:0]   seq_pc,
    output logic [XLEN-1:0]   link_pc,
    output logic [XLEN-1:0]   target
);
    localparam int UPPER_W = XLEN - JIDX_W - 2;
    localparam int SEXT_W  = XLEN - OFF_W - 2;

    logic [XLEN-1:0] jump_tgt;
    logic [XLEN-1:0] br_tgt;

    assign seq_pc   = pc + XLEN'(4);
    assign link_pc  = pc + XLEN'(8);
    assign jump_tgt = {pc[XLEN-1 -: UPPER_W], jidx, 2'b00};
    assign br_tgt   = seq_pc + {{SEXT_W{off[OFF_W-1]}}, off, 2'b00};

    always_comb begin
        unique case (kind)
            CF_JUMP: target = jump_tgt;
            CF_JREG: target = a;
            default: target = br_tgt;
        endcase
    end
endmodule

// File: rtl/npc_sequencer.sv
module npc_sequencer
    import npc_pkg::*;
#(
    parameter int          XLEN     = 32,
    parameter int          OFF_W    = 16,
    parameter int          JIDX_W   = 26,
    parameter logic [31:0] RESET_PC = 32'hBFC0_0000
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_valid,
    input  logic              in_ready,
    input  logic [3:0]        cf_kind,
    input  logic              cf_link,
    input  logic              cf_likely,
    input  logic [XLEN-1:0]   op_a,
    input  logic [XLEN-1:0]   op_b,
    input  logic [OFF_W-1:0]  br_off,
    input  logic [JIDX_W-1:0] jmp_idx,
    output logic [XLEN-1:0]   fetch_pc,
    output logic              link_we,
    output logic [XLEN-1:0]   link_data,
    output logic              annul
);
    seq_state_e      state_q, state_d;
    logic [XLEN-1:0] pc_q, pc_d;
    logic [XLEN-1:0] tgt_q, tgt_d;

    logic            step;
    logic            is_branch, cond_true, is_jump, xfer, taken;
    logic [XLEN-1:0] seq_pc, link_pc, target;

    npc_branch_cmp #(.XLEN(XLEN)) cmp_i (
        .kind      (cf_kind),
        .a         (op_a),
        .b         (op_b),
        .is_branch (is_branch),
        .cond_true (cond_true)
    );

    npc_target_gen #(.XLEN(XLEN), .OFF_W(OFF_W), .JIDX_W(JIDX_W)) tgt_i (
        .pc      (pc_q),
        .kind    (cf_kind),
        .a       (op_a),
        .off     (br_off),
        .jidx    (jmp_idx),
        .seq_pc  (seq_pc),
        .link_pc (link_pc),
        .target  (target)
    );

    assign step    = in_valid && in_ready;
    assign is_jump = (cf_kind == CF_JUMP) || (cf_kind == CF_JREG);
    assign xfer    = (state_q == SQ_RUN) && (is_jump || is_branch);
    assign taken   = is_jump || (is_branch && cond_true);

    // next-state and next-PC
    always_comb begin
        state_d = state_q;
        pc_d    = pc_q;
        tgt_d   = tgt_q;
        unique case (state_q)
            SQ_RUN: if (step) begin
                pc_d = seq_pc;
                if (xfer && taken) begin
                    state_d = SQ_SLOT;
                    tgt_d   = target;
                end else if (xfer && cf_likely && is_branch) begin
                    state_d = SQ_SQUASH;
                end
            end
            SQ_SLOT: if (step) begin
                pc_d    = tgt_q;
                state_d = SQ_RUN;
            end
            SQ_SQUASH: if (step) begin
                pc_d    = seq_pc;
                state_d = SQ_RUN;
            end
            default: state_d = SQ_RUN;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= SQ_RUN;
            pc_q    <= RESET_PC[XLEN-1:0];
            tgt_q   <= '0;
        end else begin
            state_q <= state_d;
            pc_q    <= pc_d;
            tgt_q   <= tgt_d;
        end
    end

    // outputs
    always_comb begin
        fetch_pc  = pc_q;
        link_data = link_pc;
        link_we   = step && xfer && cf_link;
        annul     = step && (state_q == SQ_SQUASH);
    end

    assert_stall_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !step |=> $stable(fetch_pc));
    assert_stall_quiet_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !step |-> (!link_we && !annul));
    assert_seq_adv_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == SQ_RUN && step && !xfer) |=> fetch_pc == $past(fetch_pc) + XLEN'(4));
    assert_slot_redirect_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == SQ_SLOT && step) |=> fetch_pc == $past(tgt_q));
    assert_annul_single_R10: assert property (@(posedge clk) disable iff (!rst_n)
        annul |=> (state_q == SQ_RUN));
    assert_slot_no_link_R12: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q != SQ_RUN) |-> !link_we);
endmodule

// File: tb/npc_sequencer_tb.sv
module npc_sequencer_tb_top;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_valid = 1'b0, in_ready = 1'b1;
    logic [3:0]  cf_kind = 4'd0;
    logic        cf_link = 1'b0, cf_likely = 1'b0;
    logic [31:0] op_a = '0, op_b = '0;
    logic [15:0] br_off = '0;
    logic [25:0] jmp_idx = '0;
    logic [31:0] fetch_pc, link_data;
    logic        link_we, annul;

    int tests = 0, fails = 0;
    bit done = 0;
    logic        cap_we, cap_an;
    logic [31:0] cap_ld;

    always #(CLK_PERIOD/2) clk = ~clk;

    npc_sequencer dut_i (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
        .cf_kind(cf_kind), .cf_link(cf_link), .cf_likely(cf_likely),
        .op_a(op_a), .op_b(op_b), .br_off(br_off), .jmp_idx(jmp_idx),
        .fetch_pc(fetch_pc), .link_we(link_we), .link_data(link_data), .annul(annul)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        tests++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic issue(input logic [3:0] k, input logic lk, input logic li,
                         input logic [31:0] a, input logic [31:0] b,
                         input logic [15:0] off, input logic [25:0] idx);
        @(negedge clk);
        in_valid = 1'b1; in_ready = 1'b1;
        cf_kind = k; cf_link = lk; cf_likely = li;
        op_a = a; op_b = b; br_off = off; jmp_idx = idx;
        #1;
        cap_we = link_we; cap_an = annul; cap_ld = link_data;
        @(posedge clk); #1;
        in_valid = 1'b0;
    endtask

    task automatic nop();
        issue(4'd0, 1'b0, 1'b0, '0, '0, '0, '0);
    endtask

    // transfer at P then slot; checks link, slot address, annul, final address
    task automatic xfer_case(input string req, input logic [3:0] k, input logic lk,
                             input logic li, input logic [31:0] a, input logic [31:0] b,
                             input logic [15:0] off, input logic [25:0] idx,
                             input bit exp_taken, input logic [31:0] exp_tgt);
        logic [31:0] p;
        p = fetch_pc;
        issue(k, lk, li, a, b, off, idx);
        chk({req, " link_we"}, 32'(cap_we), 32'(lk));
        if (lk) chk({req, " link_data (R9)"}, cap_ld, p + 32'd8);
        chk({req, " slot address (R4)"}, fetch_pc, p + 32'd4);
        nop();
        chk({req, " annul (R10/R11)"}, 32'(cap_an), 32'(li && !exp_taken));
        chk({req, " after slot"}, fetch_pc, exp_taken ? exp_tgt : p + 32'd8);
    endtask

    function automatic logic [31:0] btgt(input logic [31:0] p, input logic [15:0] off);
        return p + 32'd4 + {{14{off[15]}}, off, 2'b00};
    endfunction

    task automatic t_reset();
        repeat (3) @(posedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1 reset pc", fetch_pc, 32'hBFC0_0000);
        chk("R1 reset link_we", 32'(link_we), 0);
        chk("R1 reset annul", 32'(annul), 0);
    endtask

    task automatic t_seq();
        logic [31:0] p;
        p = fetch_pc;
        for (int i = 1; i <= 3; i++) begin
            nop();
            chk("R3 sequential", fetch_pc, p + 32'(4 * i));
        end
        p = fetch_pc;
        issue(4'd12, 1'b1, 1'b1, 32'h1, 32'h2, 16'h10, 26'h5);
        chk("R3 unused code no link", 32'(cap_we), 0);
        chk("R3 unused code advances", fetch_pc, p + 32'd4);
    endtask

    task automatic t_stall();
        logic [31:0] p, t;
        p = fetch_pc;
        @(negedge clk);
        in_valid = 1'b1; in_ready = 1'b0; cf_kind = 4'd1; cf_link = 1'b1;
        #1 chk("R2 ready-low link_we", 32'(link_we), 0);
        @(posedge clk); #1 chk("R2 ready-low hold", fetch_pc, p);
        @(negedge clk);
        in_valid = 1'b0; in_ready = 1'b1;
        #1 chk("R2 valid-low link_we", 32'(link_we), 0);
        @(posedge clk); #1 chk("R2 valid-low hold", fetch_pc, p);
        // stall while a redirect is pending
        t = {p[31:28], 26'h0000400, 2'b00};
        issue(4'd1, 1'b0, 1'b0, '0, '0, '0, 26'h0000400);
        @(negedge clk); in_valid = 1'b1; in_ready = 1'b0;
        repeat (3) @(posedge clk);
        #1 chk("R2 pending hold", fetch_pc, p + 32'd4);
        in_valid = 1'b0; in_ready = 1'b1;
        nop();
        chk("R2 pending target kept (R5)", fetch_pc, t);
    endtask

    task automatic t_jumps();
        logic [31:0] p;
        p = fetch_pc;
        xfer_case("R5 jal", 4'd1, 1'b1, 1'b0, '0, '0, '0, 26'h0123456, 1'b1,
                  {p[31:28], 26'h0123456, 2'b00});
        xfer_case("R6 jalr", 4'd2, 1'b1, 1'b0, 32'h8000_1230, '0, '0, '0, 1'b1,
                  32'h8000_1230);
    endtask

    task automatic t_branches();
        logic [31:0] p;
        p = fetch_pc;
        xfer_case("R7 beq taken back", 4'd3, 1'b0, 1'b0, 32'h55, 32'h55, 16'hFFF0, '0,
                  1'b1, btgt(p, 16'hFFF0));
        p = fetch_pc;
        xfer_case("R7 beq not taken", 4'd3, 1'b0, 1'b0, 32'h55, 32'h56, 16'h0040, '0,
                  1'b0, 0);
        p = fetch_pc;
        xfer_case("R7 bne taken", 4'd4, 1'b0, 1'b0, 32'h1, 32'h2, 16'h0020, '0,
                  1'b1, btgt(p, 16'h0020));
        p = fetch_pc;
        xfer_case("R8 gez zero", 4'd5, 1'b0, 1'b0, 32'h0, '0, 16'h0008, '0, 1'b1, btgt(p, 16'h0008));
        xfer_case("R8 gez neg", 4'd5, 1'b0, 1'b0, 32'hFFFF_FFFF, '0, 16'h0008, '0, 1'b0, 0);
        xfer_case("R8 gtz zero", 4'd6, 1'b0, 1'b0, 32'h0, '0, 16'h0008, '0, 1'b0, 0);
        p = fetch_pc;
        xfer_case("R8 gtz one", 4'd6, 1'b0, 1'b0, 32'h1, '0, 16'h0008, '0, 1'b1, btgt(p, 16'h0008));
        p = fetch_pc;
        xfer_case("R8 lez zero", 4'd7, 1'b0, 1'b0, 32'h0, '0, 16'h0004, '0, 1'b1, btgt(p, 16'h0004));
        xfer_case("R8 lez max", 4'd7, 1'b0, 1'b0, 32'h7FFF_FFFF, '0, 16'h0004, '0, 1'b0, 0);
        p = fetch_pc;
        xfer_case("R8 ltz min", 4'd8, 1'b0, 1'b0, 32'h8000_0000, '0, 16'h0004, '0, 1'b1, btgt(p, 16'h0004));
        xfer_case("R8 ltz zero", 4'd8, 1'b0, 1'b0, 32'h0, '0, 16'h0004, '0, 1'b0, 0);
        xfer_case("R9 bltzal not taken", 4'd8, 1'b1, 1'b0, 32'h5, '0, 16'h0004, '0, 1'b0, 0);
    endtask

    task automatic t_likely();
        logic [31:0] p;
        xfer_case("R10 likely not taken", 4'd3, 1'b0, 1'b1, 32'h1, 32'h2, 16'h0010, '0, 1'b0, 0);
        p = fetch_pc;
        xfer_case("R11 likely taken", 4'd4, 1'b0, 1'b1, 32'h1, 32'h2, 16'h0010, '0,
                  1'b1, btgt(p, 16'h0010));
        xfer_case("R10 likely link not taken", 4'd5, 1'b1, 1'b1, 32'hF000_0000, '0, 16'h0010, '0,
                  1'b0, 0);
    endtask

    task automatic t_slot_xfer();
        logic [31:0] p, t;
        p = fetch_pc;
        t = {p[31:28], 26'h0000200, 2'b00};
        issue(4'd1, 1'b0, 1'b0, '0, '0, '0, 26'h0000200);
        issue(4'd1, 1'b1, 1'b0, '0, '0, '0, 26'h0000300);
        chk("R12 slot transfer no link", 32'(cap_we), 0);
        chk("R12 slot transfer ignored", fetch_pc, t);
        nop();
        chk("R12 sequential after", fetch_pc, t + 32'd4);
    endtask

    initial begin
        t_reset();
        t_seq();
        t_stall();
        t_jumps();
        t_branches();
        t_likely();
        t_slot_xfer();
        done = 1;
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            tests++; fails++;
            $display("FAIL watchdog expired actual=%0d expected=%0d", 0, 1);
            $display("[TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end
endmodule